// File: doc/BRIEF.md
# USB Endpoint Event Flags and Bank Fill Unit

This block keeps the event flags of one endpoint of a USB device controller. The packet engine feeds it pulses for protocol events: a STALL handshake going out, a NAK answering an IN token, a NAK answering an OUT token, a CRC error on a received packet, and a SETUP packet arriving. The block also owns a single data bank of `BANK_BYTES` bytes. It fills the bank from a byte stream, empties it when an IN token takes the packet or software releases it, and detects overflow and underflow on its own.

Each event sets a sticky flag. Software acknowledges a flag by writing one to its clear bit. A per-flag enable mask feeds one registered endpoint interrupt. The meaning of flag bit 5 follows the endpoint type, which is a 2-bit input: 00 control, 01 isochronous, 10 bulk, 11 interrupt. The bank is run by a four-state machine. BK_EMPTY holds no packet. BK_FILL is taking bytes. BK_FULL holds a complete packet. BK_DISCARD is dropping a packet that arrived while the bank was full.

The transitions are named as follows. *Open* (BK_EMPTY to BK_FILL, on `wr_start`). *Seal* (BK_FILL to BK_FULL, on `wr_end`). *Reject* (BK_FULL to BK_DISCARD, on `wr_start`). *Resume* (BK_DISCARD to BK_FULL, on `wr_end`). *Release* (BK_FULL to BK_EMPTY, on `in_tok` or `bank_free`, when `wr_start` is low).

Top module: `usb_ep_event_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `flags` is 0, and `ep_irq`, `stall_hs`, `send_zlp` and `fill_count` are all 0. The bank starts in BK_EMPTY.
- R2: A pulse on `sw_stall_set` arms a stall request, and a pulse on `sw_stall_clr` disarms it. If both arrive in the same cycle, the request is armed. `stall_hs` is high in the cycle after `hs_req` was sampled high while the request was armed. Flag bit 0 (stall sent) sets on that same edge and on no other.
- R3: A one in `flag_clr[i]` clears flag i on the next edge, and a zero leaves it unchanged. When a set event and a clear for the same flag fall on one edge, the flag ends up set.
- R4: `ep_irq` equals the OR of `flags & flag_ien` as it stood one cycle earlier.
- R5: Flag bit 1 (CRC error) sets from `ev_crc_err` only while `ep_type` is 01. The packet being received is stored exactly as if no error had occurred.
- R6: Flag bit 3 sets from `ev_nak_in`, and flag bit 4 sets from `ev_nak_out`, on any endpoint type.
- R7: In BK_FILL, each valid byte is written at address `fill_count`, and `fill_count` then increments, until it reaches `BANK_BYTES`. Further bytes are dropped, and the first `BANK_BYTES` bytes stay readable through `rd_addr`/`rd_data`. At *Seal*, flag bit 2 (overflow) sets if any byte was dropped.
- R8: *Seal* sets flag bit 6 (packet received), with or without overflow.
- R9: *Reject* leaves the bank contents and `fill_count` unchanged until *Resume*. On an isochronous endpoint, it also sets flag bit 5 (underflow).
- R10: An `in_tok` in BK_EMPTY on an isochronous endpoint pulses `send_zlp` in the next cycle and sets flag bit 5. It does neither on other endpoint types.
- R11: On a control endpoint, flag bit 5 sets from `ev_setup_rx`. On bulk and interrupt endpoints, flag bit 5 never sets.
- R12: *Release* returns `fill_count` to 0. In BK_FULL, `wr_start` has priority over `in_tok`, and `in_tok` has priority over `bank_free`. Inputs that the current state does not use are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_type | input | 2 | Endpoint type: 00 control, 01 iso, 10 bulk, 11 interrupt |
| sw_stall_set | input | 1 | Software pulse that arms the stall request |
| sw_stall_clr | input | 1 | Software pulse that disarms the stall request |
| hs_req | input | 1 | Packet engine asks for a handshake in this slot |
| ev_nak_in | input | 1 | NAK sent for an IN token |
| ev_nak_out | input | 1 | NAK sent for an OUT token |
| ev_crc_err | input | 1 | CRC error on the received packet |
| ev_setup_rx | input | 1 | SETUP packet received |
| wr_start | input | 1 | Start of an incoming packet |
| wr_byte_vld | input | 1 | `wr_byte` is valid |
| wr_byte | input | 8 | Packet data byte |
| wr_end | input | 1 | End of the incoming packet |
| in_tok | input | 1 | IN token: the host takes the bank |
| bank_free | input | 1 | Software releases the bank |
| flag_clr | input | 7 | Write-one-to-clear per flag |
| flag_ien | input | 7 | Interrupt enable per flag |
| rd_addr | input | $clog2(BANK_BYTES) | Bank read address |
| flags | output | 7 | Sticky event flags |
| ep_irq | output | 1 | Registered endpoint interrupt |
| stall_hs | output | 1 | STALL handshake is sent this cycle |
| send_zlp | output | 1 | Zero-length packet is sent this cycle |
| fill_count | output | $clog2(BANK_BYTES+1) | Bytes held in the bank |
| rd_data | output | 8 | Bank byte at `rd_addr` |

## Verification
Two things can land on the same edge: a flag's set event and the software clear of that flag. The bench provokes this on purpose by raising `ev_nak_in` together with `flag_clr[3]`. The random phase also produces it often, because clear bits and events are drawn independently every cycle. The flag is judged to stay set (R3), and the interrupt is judged one cycle later against the model. A second collision comes from `wr_start`, `in_tok` and `bank_free` arriving together in BK_FULL. These are judged by the priority in R12.

// File: rtl/usb_ep_evt_pkg.sv
package usb_ep_evt_pkg;

    typedef enum logic [1:0] {
        EPT_CTRL = 2'b00,
        EPT_ISO  = 2'b01,
        EPT_BULK = 2'b10,
        EPT_INTR = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        BK_EMPTY,
        BK_FILL,
        BK_FULL,
        BK_DISCARD
    } bank_st_e;

    localparam int NFLAG    = 7;
    localparam int FL_STALL = 0;
    localparam int FL_CRC   = 1;
    localparam int FL_OVF   = 2;
    localparam int FL_NAKIN = 3;
    localparam int FL_NAKOUT= 4;
    localparam int FL_UNDSET= 5;
    localparam int FL_RXOUT = 6;

endpackage

// File: rtl/usb_ep_flag_bank.sv
module usb_ep_flag_bank #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    input  logic [NF-1:0] ien_i,
    output logic [NF-1:0] flags_o,
    output logic          irq_o
);

    // one sticky cell per flag; a set on the same edge as a clear wins
    for (genvar gi = 0; gi < NF; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[gi] <= 1'b0;
            else if (set_i[gi])
                flags_o[gi] <= 1'b1;
            else if (clr_i[gi])
                flags_o[gi] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |(flags_o & ien_i);
    end

endmodule

// File: rtl/usb_ep_bank_fsm.sv
module usb_ep_bank_fsm
    import usb_ep_evt_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    localparam int AW = $clog2(BANK_BYTES),
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_iso,
    input  logic          wr_start,
    input  logic          wr_byte_vld,
    input  logic [7:0]    wr_byte,
    input  logic          wr_end,
    input  logic          in_tok,
    input  logic          bank_free,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] fill_count,
    output logic          ovf_ev,
    output logic          rxout_ev,
    output logic          under_ev,
    output logic          zlp_o
);

    localparam logic [CW-1:0] CAP = CW'(BANK_BYTES);

    bank_st_e    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic        ovf_seen_q;
    logic [7:0]  mem [BANK_BYTES];
    logic        ovf_now;
    logic        in_empty_tok;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_EMPTY:   if (wr_start) st_d = BK_FILL;
            BK_FILL:    if (wr_end)   st_d = BK_FULL;
            BK_FULL: begin
                if (wr_start)                    st_d = BK_DISCARD;
                else if (in_tok || bank_free)    st_d = BK_EMPTY;
            end
            BK_DISCARD: if (wr_end)   st_d = BK_FULL;
            default:                  st_d = BK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BK_EMPTY;
        else        st_q <= st_d;
    end

    // event outputs
    always_comb begin
        ovf_now      = (st_q == BK_FILL) && wr_byte_vld && (cnt_q == CAP);
        in_empty_tok = (st_q == BK_EMPTY) && in_tok;
        rxout_ev     = (st_q == BK_FILL) && wr_end;
        ovf_ev       = rxout_ev && (ovf_seen_q || ovf_now);
        under_ev     = is_iso && (in_empty_tok || ((st_q == BK_FULL) && wr_start));
    end

    // counter, overflow memory, zero-length marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            ovf_seen_q <= 1'b0;
            zlp_o      <= 1'b0;
        end else begin
            zlp_o <= is_iso && in_empty_tok;
            if (st_q == BK_EMPTY && wr_start)
                ovf_seen_q <= 1'b0;
            else if (ovf_now)
                ovf_seen_q <= 1'b1;
            if (st_q == BK_FILL && wr_byte_vld && cnt_q != CAP)
                cnt_q <= cnt_q + 1'b1;
            else if (st_q == BK_FULL && !wr_start && (in_tok || bank_free))
                cnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == BK_FILL && wr_byte_vld && cnt_q != CAP)
            mem[cnt_q[AW-1:0]] <= wr_byte;
    end

    assign rd_data    = mem[rd_addr];
    assign fill_count = cnt_q;

endmodule

// File: rtl/usb_ep_event_unit.sv
module usb_ep_event_unit
    import usb_ep_evt_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    localparam int AW = $clog2(BANK_BYTES),
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ep_type,
    input  logic             sw_stall_set,
    input  logic             sw_stall_clr,
    input  logic             hs_req,
    input  logic             ev_nak_in,
    input  logic             ev_nak_out,
    input  logic             ev_crc_err,
    input  logic             ev_setup_rx,
    input  logic             wr_start,
    input  logic             wr_byte_vld,
    input  logic [7:0]       wr_byte,
    input  logic             wr_end,
    input  logic             in_tok,
    input  logic             bank_free,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] flag_ien,
    input  logic [AW-1:0]    rd_addr,
    output logic [NFLAG-1:0] flags,
    output logic             ep_irq,
    output logic             stall_hs,
    output logic             send_zlp,
    output logic [CW-1:0]    fill_count,
    output logic [7:0]       rd_data
);

    ep_kind_e         kind;
    logic             is_iso;
    logic             stall_armed_q;
    logic             stall_go;
    logic             ovf_ev, rxout_ev, under_ev;
    logic [NFLAG-1:0] set_vec;

    assign kind     = ep_kind_e'(ep_type);
    assign is_iso   = (kind == EPT_ISO);
    assign stall_go = hs_req && stall_armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_armed_q <= 1'b0;
            stall_hs      <= 1'b0;
        end else begin
            stall_hs <= stall_go;
            if (sw_stall_set)      stall_armed_q <= 1'b1;
            else if (sw_stall_clr) stall_armed_q <= 1'b0;
        end
    end

    always_comb begin
        set_vec            = '0;
        set_vec[FL_STALL]  = stall_go;
        set_vec[FL_CRC]    = ev_crc_err && is_iso;
        set_vec[FL_OVF]    = ovf_ev;
        set_vec[FL_NAKIN]  = ev_nak_in;
        set_vec[FL_NAKOUT] = ev_nak_out;
        set_vec[FL_RXOUT]  = rxout_ev;
        unique case (kind)
            EPT_CTRL:           set_vec[FL_UNDSET] = ev_setup_rx;
            EPT_ISO:            set_vec[FL_UNDSET] = under_ev;
            EPT_BULK, EPT_INTR: set_vec[FL_UNDSET] = 1'b0;
            default:            set_vec[FL_UNDSET] = 1'b0;
        endcase
    end

    usb_ep_bank_fsm #(.BANK_BYTES(BANK_BYTES)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_iso     (is_iso),
        .wr_start   (wr_start),
        .wr_byte_vld(wr_byte_vld),
        .wr_byte    (wr_byte),
        .wr_end     (wr_end),
        .in_tok     (in_tok),
        .bank_free  (bank_free),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .fill_count (fill_count),
        .ovf_ev     (ovf_ev),
        .rxout_ev   (rxout_ev),
        .under_ev   (under_ev),
        .zlp_o      (send_zlp)
    );

    usb_ep_flag_bank #(.NF(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (flag_clr),
        .ien_i  (flag_ien),
        .flags_o(flags),
        .irq_o  (ep_irq)
    );

endmodule

// File: rtl/usb_ep_event_chk.sv
module usb_ep_event_chk #(
    parameter int NF = 7,
    parameter int BANK_BYTES = 64,
    localparam int CW = $clog2(BANK_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    ep_type,
    input logic [NF-1:0] clr,
    input logic [NF-1:0] ien,
    input logic [NF-1:0] flags,
    input logic          ep_irq,
    input logic          hs_req,
    input logic          stall_hs,
    input logic          send_zlp,
    input logic [CW-1:0] fill_count,
    input logic [NF-1:0] set_vec
);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R3
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set_vec)) |=> ((flags & $past(clr & ~set_vec)) == '0)); // R3
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0 && set_vec == '0) |=> (flags == $past(flags))); // R3
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ep_irq == |($past(flags) & $past(ien)))); // R4
    AST_CRC_ISO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_type != 2'b01) |=> !$rose(flags[1])); // R5
    AST_BIT5_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ep_type[1] |=> !$rose(flags[5])); // R11
    AST_STALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stall_hs |-> $past(hs_req)); // R2
    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(BANK_BYTES)); // R7
    AST_ZLP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        send_zlp |-> (fill_count == '0)); // R10

endmodule

bind usb_ep_event_unit usb_ep_event_chk #(.NF(usb_ep_evt_pkg::NFLAG), .BANK_BYTES(BANK_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ep_type   (ep_type),
    .clr       (flag_clr),
    .ien       (flag_ien),
    .flags     (flags),
    .ep_irq    (ep_irq),
    .hs_req    (hs_req),
    .stall_hs  (stall_hs),
    .send_zlp  (send_zlp),
    .fill_count(fill_count),
    .set_vec   (set_vec)
);

// File: tb/tb_usb_ep_event_unit.sv
module tb_usb_ep_event_unit;

    localparam int B  = 8;
    localparam int AW = $clog2(B);
    localparam int CW = $clog2(B + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ep_type = 2'b01;
    logic sw_stall_set = 0, sw_stall_clr = 0, hs_req = 0;
    logic ev_nak_in = 0, ev_nak_out = 0, ev_crc_err = 0, ev_setup_rx = 0;
    logic wr_start = 0, wr_byte_vld = 0, wr_end = 0, in_tok = 0, bank_free = 0;
    logic [7:0] wr_byte = 8'h00;
    logic [6:0] flag_clr = '0, flag_ien = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [6:0] flags;
    logic ep_irq, stall_hs, send_zlp;
    logic [CW-1:0] fill_count;
    logic [7:0] rd_data;

    always #10 clk = ~clk;

    usb_ep_event_unit #(.BANK_BYTES(B)) dut (
        .clk(clk), .rst_n(rst_n), .ep_type(ep_type),
        .sw_stall_set(sw_stall_set), .sw_stall_clr(sw_stall_clr), .hs_req(hs_req),
        .ev_nak_in(ev_nak_in), .ev_nak_out(ev_nak_out), .ev_crc_err(ev_crc_err),
        .ev_setup_rx(ev_setup_rx), .wr_start(wr_start), .wr_byte_vld(wr_byte_vld),
        .wr_byte(wr_byte), .wr_end(wr_end), .in_tok(in_tok), .bank_free(bank_free),
        .flag_clr(flag_clr), .flag_ien(flag_ien), .rd_addr(rd_addr),
        .flags(flags), .ep_irq(ep_irq), .stall_hs(stall_hs), .send_zlp(send_zlp),
        .fill_count(fill_count), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [6:0] m_flags;
    logic m_irq, m_sreq, m_shs, m_zlp, m_ovf;
    int m_st;   // 0 empty, 1 fill, 2 full, 3 discard
    int m_cnt;
    logic [7:0] m_mem [B];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] calc_set();
        logic [6:0] s;
        logic iso, fill, ovf_now;
        iso  = (ep_type == 2'b01);
        fill = (m_st == 1);
        ovf_now = fill && wr_byte_vld && (m_cnt == B);
        s = '0;
        s[0] = hs_req && m_sreq;
        s[1] = ev_crc_err && iso;
        s[2] = fill && wr_end && (m_ovf || ovf_now);
        s[3] = ev_nak_in;
        s[4] = ev_nak_out;
        if (ep_type == 2'b00)
            s[5] = ev_setup_rx;
        else if (iso)
            s[5] = (m_st == 2 && wr_start) || (m_st == 0 && in_tok);
        s[6] = fill && wr_end;
        return s;
    endfunction

    task automatic model_reset();
        m_flags = '0; m_irq = 0; m_sreq = 0; m_shs = 0; m_zlp = 0; m_ovf = 0;
        m_st = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        logic [6:0] s;
        logic iso;
        s = calc_set();
        iso = (ep_type == 2'b01);
        m_irq = |(m_flags & flag_ien);
        m_flags = s | (m_flags & ~flag_clr);
        m_shs = hs_req && m_sreq;
        m_sreq = sw_stall_set || (m_sreq && !sw_stall_clr);
        m_zlp = iso && (m_st == 0) && in_tok;
        case (m_st)
            0: if (wr_start) begin m_st = 1; m_ovf = 0; end
            1: begin
                if (wr_byte_vld) begin
                    if (m_cnt < B) begin m_mem[m_cnt] = wr_byte; m_cnt++; end
                    else m_ovf = 1;
                end
                if (wr_end) m_st = 2;
            end
            2: begin
                if (wr_start) m_st = 3;
                else if (in_tok || bank_free) begin m_st = 0; m_cnt = 0; end
            end
            default: if (wr_end) m_st = 2;
        endcase
    endtask

    task automatic compare();
        chk("R3 flags", 32'(flags), 32'(m_flags));
        chk("R4 irq", 32'(ep_irq), 32'(m_irq));
        chk("R2 stall_hs", 32'(stall_hs), 32'(m_shs));
        chk("R10 send_zlp", 32'(send_zlp), 32'(m_zlp));
        chk("R12 fill_count", 32'(fill_count), 32'(m_cnt));
        if (int'(rd_addr) < m_cnt)
            chk("R7 rd_data", 32'(rd_data), 32'(m_mem[rd_addr]));
    endtask

    task automatic quiet();
        sw_stall_set = 0; sw_stall_clr = 0; hs_req = 0;
        ev_nak_in = 0; ev_nak_out = 0; ev_crc_err = 0; ev_setup_rx = 0;
        wr_start = 0; wr_byte_vld = 0; wr_end = 0; in_tok = 0; bank_free = 0;
        flag_clr = '0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        quiet();
    endtask

    task automatic load_pkt(input int n, input logic [7:0] base);
        wr_start = 1; tick();
        for (int i = 0; i < n; i++) begin
            wr_byte_vld = 1; wr_byte = base + 8'(i); tick();
        end
        wr_end = 1; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F0E_5EED));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flags", 32'(flags), 0);
        chk("R1 irq", 32'(ep_irq), 0);
        chk("R1 fill_count", 32'(fill_count), 0);
        rst_n = 1;
        @(negedge clk);
        compare();

        // iso packet with CRC error is still stored: R5 R8
        ep_type = 2'b01; flag_ien = 7'h7F;
        wr_start = 1; tick();
        wr_byte_vld = 1; wr_byte = 8'hA0; ev_crc_err = 1; tick();
        wr_byte_vld = 1; wr_byte = 8'hA1; tick();
        wr_end = 1; tick();
        chk("R5 crc flag", 32'(flags[1]), 1);
        chk("R8 rxout flag", 32'(flags[6]), 1);
        rd_addr = 3'd1; @(negedge clk);
        chk("R5 stored byte", 32'(rd_data), 32'h A1);

        // R9 reject while full keeps contents and flags underflow
        flag_clr = 7'h7F; tick();
        load_pkt(3, 8'h10);
        chk("R9 full count", 32'(fill_count), 2);
        chk("R9 underflow", 32'(flags[5]), 1);
        rd_addr = 3'd0; @(negedge clk);
        chk("R9 byte kept", 32'(rd_data), 32'hA0);

        // R12 priority: wr_start over in_tok; then in_tok releases
        flag_clr = 7'h7F; wr_start = 1; in_tok = 1; tick();
        chk("R12 start wins", 32'(fill_count), 2);
        wr_end = 1; tick();
        in_tok = 1; bank_free = 1; tick();
        chk("R12 released", 32'(fill_count), 0);

        // R10 empty iso IN -> zlp
        in_tok = 1; tick();
        chk("R10 zlp", 32'(send_zlp), 1);

        // R7 overflow keeps first B bytes
        flag_clr = 7'h7F; tick();
        load_pkt(B + 3, 8'h40);
        chk("R7 count capped", 32'(fill_count), B);
        chk("R7 ovf flag", 32'(flags[2]), 1);
        chk("R8 rxout on ovf", 32'(flags[6]), 1);
        rd_addr = 3'(B - 1); @(negedge clk);
        chk("R7 last kept", 32'(rd_data), 32'h40 + B - 1);
        bank_free = 1; tick();

        // R11 bulk ignores setup, no zlp on bulk; control sets bit 5
        flag_clr = 7'h7F; tick();
        ep_type = 2'b10; ev_setup_rx = 1; in_tok = 1; tick();
        tick();
        chk("R11 bulk bit5", 32'(flags[5]), 0);
        chk("R10 no zlp bulk", 32'(send_zlp), 0);
        ep_type = 2'b00; ev_setup_rx = 1; tick();
        chk("R11 ctrl setup", 32'(flags[5]), 1);

        // R6 NAKs; R3 set beats clear
        ev_nak_out = 1; tick();
        chk("R6 nak out", 32'(flags[4]), 1);
        ev_nak_in = 1; flag_clr = 7'b0001000; tick();
        chk("R3 set wins", 32'(flags[3]), 1);
        flag_clr = 7'b0001000; tick();
        chk("R3 clear", 32'(flags[3]), 0);

        // R2 stall
        hs_req = 1; tick();
        chk("R2 no stall unarmed", 32'(stall_hs), 0);
        sw_stall_set = 1; sw_stall_clr = 1; tick();
        hs_req = 1; tick();
        chk("R2 stall sent", 32'(stall_hs), 1);
        chk("R2 stall flag", 32'(flags[0]), 1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if (n % 64 == 0) ep_type = 2'($urandom);
            if (n % 50 == 0) flag_ien = 7'($urandom);
            wr_start    = ($urandom % 8) == 0;
            wr_byte_vld = ($urandom % 2) == 0;
            wr_byte     = 8'($urandom);
            wr_end      = ($urandom % 10) == 0;
            in_tok      = ($urandom % 12) == 0;
            bank_free   = ($urandom % 16) == 0;
            hs_req      = ($urandom % 6) == 0;
            sw_stall_set= ($urandom % 20) == 0;
            sw_stall_clr= ($urandom % 20) == 0;
            ev_nak_in   = ($urandom % 10) == 0;
            ev_nak_out  = ($urandom % 10) == 0;
            ev_crc_err  = ($urandom % 10) == 0;
            ev_setup_rx = ($urandom % 10) == 0;
            flag_clr    = 7'($urandom & $urandom & $urandom);
            rd_addr     = AW'($urandom);
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule